// File: doc/BRIEF.md
# Sampling ADC serial-output interface

This block is the device-side digital half of a 12-bit sampling converter's serial port. The host lowers chip select to start a cycle. At that moment the block captures the parallel conversion result from the converter stand-in. It then shifts out a 16-bit word on the serial clock: two zero bits, the twelve result bits with the most significant bit first, and two zero bits. The data line is only enabled while chip select is low.

The block also tracks where in the frame chip select returns high. If that happens after the conversion point, the device moves to acquisition. If it happens earlier, the conversion is aborted. If it happens inside a window early in the frame, the device also drops into power-down. A status bit tells the host whether the word being shifted out comes from a preceding cycle that reached acquisition. A power-down flag stays set until a full cycle brings the device back to the acquisition point.

Chip select and the serial clock are oversampled by the block clock through a configurable synchroniser. Every event described below therefore takes effect `SYNC_STAGES + 1` block-clock edges after the pin changes.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the data enable, data line, abort pulse, power-down flag and data-valid status are all 0, and the phase output is acquisition (code 0).
- R2: A falling chip select starts a cycle. The data enable goes to 1 and the first bit driven is 0. The result input is captured at that point.
- R3: The frame is bit positions 15 down to 0, holding {0, 0, result[11:0], 0, 0}. Bit 15 is driven from the chip-select fall. Each serial-clock falling edge advances to the next bit. After 16 falling edges the line stays 0.
- R4: While chip select is high, the data enable is 0 and the data line is 0.
- R5: The phase output is 1 (conversion) from the chip-select fall until the first serial-clock rising edge after the 13th falling edge. At that rising edge it becomes 0 (acquisition), even if chip select is still low.
- R6: If chip select rises while the phase is conversion, the abort output pulses high for exactly one clock.
- R7: If chip select rises during conversion with a falling-edge count of 2 to 9 inclusive, the power-down flag is set and the phase becomes 2 (power-down).
- R8: If chip select rises during conversion with a falling-edge count below 2 or of 10 to 13, the block aborts without setting the power-down flag.
- R9: At each chip-select fall, the data-valid status is updated to 1 only if the previous cycle reached the acquisition point. Otherwise it is 0. The status holds until the next fall.
- R10: The power-down flag clears at the acquisition point of the next complete cycle. That wake-up cycle reports data-valid 0.
- R11: Serial-clock activity while chip select is high has no effect: the enable stays 0, and the next frame starts from bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| result_i | input | DATA_W | Parallel conversion result from the converter stand-in |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for the data pad (0 means high impedance) |
| phase_o | output | 2 | 0 acquisition, 1 conversion, 2 power-down |
| dvalid_o | output | 1 | Current word follows a cycle that reached acquisition |
| abort_o | output | 1 | One-clock pulse on an aborted conversion |
| pdown_o | output | 1 | Power-down flag |

## Verification
A falling-edge counter that is off by one shows up within one serial-clock period. It appears as a shifted data bit, a conversion end one edge early or late, or a power-down decision flipped at the window edges (counts 1, 2, 9 and 10 are all driven). A stuck phase state, or a lost acquisition record, is hidden until the next chip-select fall. At that fall it shows as a wrong data-valid bit, or as a power-down flag that fails to clear. For this reason the bench always runs a further cycle after each abort or wake-up.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;

   typedef enum logic [1:0] {
      PH_ACQ   = 2'd0,
      PH_CONV  = 2'd1,
      PH_PDOWN = 2'd2
   } phase_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CONV = 2'd1,
      ST_DONE = 2'd2
   } fsm_e;

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);

   logic prev_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign level = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         for (genvar i = 0; i < STAGES; i++) begin : g_st
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[0] <= RST_VAL;
                  else        chain[0] <= din;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) chain[i] <= RST_VAL;
                  else        chain[i] <= chain[i-1];
               end
            end
         end
         assign level = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;

endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
   parameter int DATA_W  = 12,
   parameter int LEAD_Z  = 2,
   parameter int TRAIL_Z = 2,
   localparam int FRAME_W = LEAD_Z + DATA_W + TRAIL_Z
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] data,
   output logic              bit_o
);

   logic [FRAME_W-1:0] sreg;
   logic [FRAME_W-1:0] word;

   assign word = {{LEAD_Z{1'b0}}, data, {TRAIL_Z{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sreg <= '0;
      else if (load)  sreg <= word;
      else if (shift) sreg <= {sreg[FRAME_W-2:0], 1'b0};
   end

   assign bit_o = sreg[FRAME_W-1];

endmodule

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl
   import adc_serial_pkg::*;
#(
   parameter int FRAME_W   = 16,
   parameter int DONE_FALL = 13,
   parameter int PD_LO     = 2,
   parameter int PD_HI     = 9,
   localparam int CNT_W    = $clog2(FRAME_W + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_rise,
   input  logic       cs_fall,
   input  logic       sc_rise,
   input  logic       sc_fall,
   output logic       load,
   output logic       shift,
   output logic       active,
   output logic [1:0] phase,
   output logic       dvalid,
   output logic       abort,
   output logic       pdown
);

   fsm_e             state;
   logic [CNT_W-1:0] nfall;
   logic             reached;
   logic             in_win;
   logic             at_done;

   assign active  = (state != ST_IDLE);
   assign load    = cs_fall & ~active;
   assign shift   = sc_fall & active & ~cs_rise;
   assign in_win  = (nfall >= CNT_W'(PD_LO)) && (nfall <= CNT_W'(PD_HI));
   assign at_done = (nfall >= CNT_W'(DONE_FALL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         nfall   <= '0;
         reached <= 1'b0;
         dvalid  <= 1'b0;
         abort   <= 1'b0;
         pdown   <= 1'b0;
      end else begin
         abort <= 1'b0;
         if (cs_rise && active) begin
            if (state == ST_CONV) begin
               abort   <= 1'b1;
               reached <= 1'b0;
               if (in_win) pdown <= 1'b1;
            end
            state <= ST_IDLE;
         end else if (load) begin
            state  <= ST_CONV;
            nfall  <= '0;
            dvalid <= reached;
         end else if (active) begin
            if (sc_fall && nfall != CNT_W'(FRAME_W)) nfall <= nfall + 1'b1;
            if (state == ST_CONV && sc_rise && at_done) begin
               state   <= ST_DONE;
               reached <= 1'b1;
               pdown   <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      if (state == ST_CONV) phase = PH_CONV;
      else if (pdown)       phase = PH_PDOWN;
      else                  phase = PH_ACQ;
   end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
   parameter int DATA_W      = 12,
   parameter int LEAD_Z      = 2,
   parameter int TRAIL_Z     = 2,
   parameter int PD_LO       = 2,
   parameter int PD_HI       = 9,
   parameter int SYNC_STAGES = 2,
   localparam int FRAME_W    = LEAD_Z + DATA_W + TRAIL_Z,
   localparam int DONE_FALL  = LEAD_Z - 1 + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic [DATA_W-1:0] result_i,
   output logic              sdo,
   output logic              sdo_oe,
   output logic [1:0]        phase_o,
   output logic              dvalid_o,
   output logic              abort_o,
   output logic              pdown_o
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (LEAD_Z < 1) begin : g_bad_lead
         $error("LEAD_Z must be at least 1");
      end
      if (TRAIL_Z < 0) begin : g_bad_trail
         $error("TRAIL_Z must not be negative");
      end
      if (PD_LO > PD_HI || PD_HI >= DONE_FALL) begin : g_bad_win
         $error("power-down window must lie before the conversion end");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic cs_lvl, cs_rise, cs_fall;
   logic sc_lvl, sc_rise, sc_fall;
   logic load, shift, active, bit_w;

   adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .din(cs_n),
      .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
   );

   adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sc_sync (
      .clk(clk), .rst_n(rst_n), .din(sclk),
      .level(sc_lvl), .rise(sc_rise), .fall(sc_fall)
   );

   adc_phase_ctrl #(
      .FRAME_W(FRAME_W), .DONE_FALL(DONE_FALL), .PD_LO(PD_LO), .PD_HI(PD_HI)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cs_rise(cs_rise), .cs_fall(cs_fall), .sc_rise(sc_rise), .sc_fall(sc_fall),
      .load(load), .shift(shift), .active(active), .phase(phase_o),
      .dvalid(dvalid_o), .abort(abort_o), .pdown(pdown_o)
   );

   adc_frame_shift #(.DATA_W(DATA_W), .LEAD_Z(LEAD_Z), .TRAIL_Z(TRAIL_Z)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
      .data(result_i), .bit_o(bit_w)
   );

   assign sdo_oe = active;
   assign sdo    = bit_w & active;

   logic unused_lvl;
   assign unused_lvl = sc_lvl;

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_lvl,
   input logic       sdo,
   input logic       sdo_oe,
   input logic [1:0] phase_o,
   input logic       dvalid_o,
   input logic       abort_o,
   input logic       pdown_o
);

   p_oe_off_cs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_lvl) |-> !sdo_oe);

   p_quiet_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !sdo);

   p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> !abort_o);

   p_abort_from_conv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> $past(phase_o) == 2'd1);

   p_pd_from_conv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdown_o) |-> $past(phase_o) == 2'd1 && abort_o);

   p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && $past(sdo_oe)) |-> $stable(dvalid_o));

   p_pd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pdown_o) |-> phase_o == 2'd0 && $past(phase_o) == 2'd1);

endmodule

bind adc_serial_port adc_serial_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .sdo(sdo), .sdo_oe(sdo_oe),
   .phase_o(phase_o), .dvalid_o(dvalid_o), .abort_o(abort_o), .pdown_o(pdown_o)
);

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;

   localparam int SYNC = 2;
   localparam int HALF = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic [11:0] result_i = '0;
   logic        sdo, sdo_oe, dvalid_o, abort_o, pdown_o;
   logic [1:0]  phase_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   int aborts = 0;

   always #4 clk = ~clk;

   adc_serial_port uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .result_i(result_i),
      .sdo(sdo), .sdo_oe(sdo_oe), .phase_o(phase_o), .dvalid_o(dvalid_o),
      .abort_o(abort_o), .pdown_o(pdown_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: delayed pin history, then frame rules
   logic [1:0]  hist[$];
   int          m_st, m_cnt;
   logic [15:0] m_word;
   bit          m_pd, m_ok, m_valid, m_abort;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i < SYNC + 2; i++) hist.push_back(2'b11);
         m_st = 0; m_cnt = 0; m_word = '0;
         m_pd = 0; m_ok = 0; m_valid = 0; m_abort = 0;
      end else begin
         bit cn, cp, sn, sp;
         hist.push_front({cs_n, sclk});
         void'(hist.pop_back());
         cn = hist[SYNC][1];   cp = hist[SYNC+1][1];
         sn = hist[SYNC][0];   sp = hist[SYNC+1][0];
         m_abort = 0;
         if (cn && !cp) begin
            if (m_st == 1) begin
               m_abort = 1; m_ok = 0;
               if (m_cnt >= 2 && m_cnt <= 9) m_pd = 1;
            end
            m_st = 0;
         end else if (!cn && cp) begin
            m_st = 1; m_cnt = 0; m_valid = m_ok;
            m_word = {2'b00, result_i, 2'b00};
         end else if (m_st != 0) begin
            if (sp && !sn) begin
               m_word = m_word << 1;
               if (m_cnt < 16) m_cnt++;
            end
            if (m_st == 1 && !sp && sn && m_cnt >= 13) begin
               m_st = 2; m_pd = 0; m_ok = 1;
            end
         end
      end
   end

   // compare with the reference every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         int exp_ph;
         exp_ph = (m_st == 1) ? 1 : (m_pd ? 2 : 0);
         chk(sdo_oe == (m_st != 0), "R4", sdo_oe, m_st != 0);
         chk(sdo == ((m_st != 0) && m_word[15]), "R3", sdo, (m_st != 0) && m_word[15]);
         chk(abort_o == m_abort, "R6", abort_o, m_abort);
         chk(pdown_o == m_pd, "R7", pdown_o, m_pd);
         chk(dvalid_o == m_valid, "R9", dvalid_o, m_valid);
         chk(int'(phase_o) == exp_ph, "R5", phase_o, exp_ph);
         if (abort_o) aborts++;
      end
   end

   // one cycle: nf falling edges; the last rising edge is dropped when tail_rise is 0
   task automatic frame(input logic [11:0] data, input int nf, input bit tail_rise);
      result_i = data;
      @(negedge clk) cs_n = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
      chk(sdo_oe == 1'b1, "R2", sdo_oe, 1);
      chk(sdo == 1'b0, "R2", sdo, 0);
      for (int i = 1; i <= nf; i++) begin
         sclk = 1'b0;
         repeat (HALF) @(negedge clk);
         if (i < nf || tail_rise) begin
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
         end
      end
      repeat (SYNC + 1) @(negedge clk);
      if (nf >= 13 && tail_rise) chk(phase_o == 2'd0, "R5", phase_o, 0);
      if (nf == 13 && !tail_rise) chk(phase_o == 2'd1, "R5", phase_o, 1);
      sclk = 1'b1;
      cs_n = 1'b1;
      repeat (SYNC + 8) @(negedge clk);
   endtask

   initial begin
      int a0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(sdo_oe == 0 && sdo == 0, "R1", sdo_oe, 0);
      chk(pdown_o == 0 && dvalid_o == 0 && abort_o == 0, "R1", pdown_o, 0);
      chk(phase_o == 2'd0, "R1", phase_o, 0);

      frame(12'hA5C, 16, 1);
      chk(dvalid_o == 0, "R9", dvalid_o, 0);
      frame(12'h3C7, 16, 1);
      chk(dvalid_o == 1, "R9", dvalid_o, 1);
      frame(12'hFFF, 13, 1);
      chk(phase_o == 2'd0, "R5", phase_o, 0);

      a0 = aborts;
      frame(12'h001, 13, 0);
      chk(aborts == a0 + 1, "R6", aborts, a0 + 1);
      chk(pdown_o == 0, "R8", pdown_o, 0);
      frame(12'h800, 16, 1);
      chk(dvalid_o == 0, "R9", dvalid_o, 0);

      frame(12'h555, 5, 1);
      chk(pdown_o == 1 && phase_o == 2'd2, "R7", pdown_o, 1);
      frame(12'hAAA, 16, 1);
      chk(pdown_o == 0, "R10", pdown_o, 0);
      chk(dvalid_o == 0, "R10", dvalid_o, 0);
      frame(12'h6B9, 16, 1);
      chk(dvalid_o == 1, "R9", dvalid_o, 1);

      frame(12'h123, 2, 1);
      chk(pdown_o == 1, "R7", pdown_o, 1);
      frame(12'h456, 16, 1);
      frame(12'h789, 9, 1);
      chk(pdown_o == 1, "R7", pdown_o, 1);
      frame(12'hBCD, 16, 1);

      a0 = aborts;
      frame(12'hE0F, 1, 1);
      chk(pdown_o == 0, "R8", pdown_o, 0);
      frame(12'h0F0, 10, 1);
      chk(pdown_o == 0, "R8", pdown_o, 0);
      chk(aborts == a0 + 2, "R6", aborts, a0 + 2);

      // R11 serial clock toggles while deselected
      for (int i = 0; i < 6; i++) begin
         sclk = ~sclk;
         repeat (HALF + SYNC) @(negedge clk);
         chk(sdo_oe == 0, "R11", sdo_oe, 0);
      end
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      frame(12'hC3A, 16, 1);
      frame(12'h7E1, 16, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule